// File: doc/BRIEF.md
# ASK Power-Level Ramp Sequencer

This block chooses the drive setting for a power amplifier during amplitude-keyed transmission. A small table holds up to eight programmed amplifier settings. A transmitted 0 uses table entry 0, and a transmitted 1 uses the entry at a programmable top index. When the data bit changes, the block does not jump straight between the two settings. It steps through every intermediate table entry, one entry per step-tick, so the edges of the transmitted envelope are shaped.

The transmit datapath supplies the data bit and a step-tick strobe whose rate sets how long an edge takes to ramp. Software or a configuration block loads the table through a simple write port and sets the top index. For plain on-off keying, set the top index to 1 and load the off level into entry 0 and the on level into entry 1. The block outputs the current table index and the registered amplifier setting taken from that entry.

Top module: `ask_ramp_seq`

## Requirements
- R1: While `rst_n` is sampled low, and in the first cycle after it is released, `cur_idx` is 0 and `pa_level` is 0. Reset also clears every table entry to 0.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored in the entry addressed by `wr_addr` (entries are numbered 0 to 7). The new value is used from the next cycle onward.
- R3: When `data_bit` is 1, `step_tick` is high and `cur_idx` is below `top_idx`, `cur_idx` rises by exactly one at that clock edge. When `cur_idx` has reached `top_idx`, it stays there.
- R4: When `data_bit` is 0 and `step_tick` is high, `cur_idx` falls by one at each such edge until it reaches 0, and then stays at 0.
- R5: If `data_bit` reverses partway through a ramp, the next ticks move the index the other way, starting from the index it has reached. The index is never reset to an end point.
- R6: If `top_idx` is lowered below `cur_idx` while `data_bit` is 1, each tick lowers `cur_idx` by one until it equals the new `top_idx`.
- R7: `cur_idx` changes only at an edge where `step_tick` was high, and it changes by at most one per edge.
- R8: At each clock edge, `pa_level` takes the table entry addressed by `cur_idx` as it stood before that edge, using the table contents from before that edge.
- R9: With `top_idx` = 1 the block gives plain on-off keying: a single tick moves the index between 0 and 1.
- R10: With `top_idx` = 0 the data bit has no effect, and `cur_idx` stays at 0 whatever ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_bit | input | 1 | Keyed data: 0 selects entry 0, 1 selects the top index |
| step_tick | input | 1 | Enables one ramp step at this edge |
| top_idx | input | IDX_W (3) | Table index used while sending a 1 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDX_W (3) | Table entry to write |
| wr_data | input | VAL_W (8) | Amplifier setting to store |
| cur_idx | output | IDX_W (3) | Table index currently selected |
| pa_level | output | VAL_W (8) | Registered amplifier setting |

## Verification
The bench builds the block with its default parameters: eight table entries and 8-bit settings. With these values the top index can reach 7, so a full-height ramp, saturation at both ends, reversals partway up, and lowering the top index from 7 can all be driven. The same build also covers the one-step on-off keying case and the degenerate case where the top index is 0. Every table entry is loaded with a distinct value, so a wrong index shows up as a wrong `pa_level`. A write to the entry currently selected checks when new contents reach the output.

// File: rtl/ask_ramp_pkg.sv
// Shared types for the ASK ramp sequencer.
// Assumes: nothing beyond standard SystemVerilog packages.
package ask_ramp_pkg;
    // Direction the ramp index takes at the next tick
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/ramp_level_table.sv
// Level table: LEVELS registers of VAL_W bits, written through one write
// port and read combinationally by index.
// Assumes: rd_idx < LEVELS and wr_addr < LEVELS (LEVELS is a power of two).
module ramp_level_table #(
    parameter int LEVELS = 8,
    parameter int VAL_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_val
);
    logic [VAL_W-1:0] entries [LEVELS];
    logic [LEVELS-1:0] wr_hit;

    // Decode one write-select line per entry
    for (genvar i = 0; i < LEVELS; i++) begin : g_hit
        assign wr_hit[i] = wr_en && (wr_addr == IDX_W'(i));
    end

    // Store the write data in the selected entry; clear all entries on reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < LEVELS; i++) begin
            if (!rst_n)
                entries[i] <= '0;
            else if (wr_hit[i])
                entries[i] <= wr_data;
        end
    end

    // Select the entry addressed by the read index
    always_comb rd_val = entries[rd_idx];

    // R2
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> entries[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ramp_index_walker.sv
// Index walker: moves the table index one step toward its target on each
// step tick. The target is the top index for data 1 and 0 for data 0.
// Assumes: top_idx stays within the table.
module ramp_index_walker
    import ask_ramp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_bit,
    input  logic             step_tick,
    input  logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] target;
    ramp_dir_e        dir;

    // Choose the end point the ramp heads toward
    always_comb target = data_bit ? top_idx : '0;

    // Decide whether the next tick moves up, down, or not at all
    always_comb begin
        if (!step_tick || idx == target) dir = RAMP_HOLD;
        else if (idx < target)           dir = RAMP_UP;
        else                             dir = RAMP_DOWN;
    end

    // Apply one step per tick; reset to index 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else begin
            case (dir)
                RAMP_UP:   idx <= idx + IDX_W'(1);
                RAMP_DOWN: idx <= idx - IDX_W'(1);
                default:   idx <= idx;
            endcase
        end
    end

    // R7
    only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(idx));
    // R3
    climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && data_bit && idx < top_idx) |=> idx == $past(idx) + IDX_W'(1));
    // R4
    descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && !data_bit && idx != '0) |=> idx == $past(idx) - IDX_W'(1));
    // R6
    lower_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && data_bit && idx > top_idx) |=> idx == $past(idx) - IDX_W'(1));
endmodule

// File: rtl/ask_ramp_seq.sv
// ASK power-level ramp sequencer: walks a table index between 0 and a
// programmable top index as the keyed data changes, and registers the table
// entry at that index as the amplifier setting.
// Assumes: LEVELS is a power of two, and top_idx/wr_addr address existing entries.
module ask_ramp_seq #(
    parameter int LEVELS = 8,
    parameter int VAL_W  = 8,
    localparam int IDX_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_bit,
    input  logic             step_tick,
    input  logic [IDX_W-1:0] top_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [VAL_W-1:0] wr_data,
    output logic [IDX_W-1:0] cur_idx,
    output logic [VAL_W-1:0] pa_level
);
    logic [VAL_W-1:0] tab_val;

    ramp_index_walker #(.IDX_W(IDX_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_bit  (data_bit),
        .step_tick (step_tick),
        .top_idx   (top_idx),
        .idx       (cur_idx)
    );

    ramp_level_table #(.LEVELS(LEVELS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (cur_idx),
        .rd_val  (tab_val)
    );

    // Register the selected setting once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) pa_level <= '0;
        else        pa_level <= tab_val;
    end

    // R10
    zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_idx == '0 && cur_idx == '0) |=> cur_idx == '0);
endmodule

// File: tb/sim_ask_ramp_seq.sv
// Scoreboard bench for ask_ramp_seq: the driver task predicts each cycle's
// outputs and queues them; the monitor compares them at the falling edge.
module sim_ask_ramp_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       data_bit, step_tick, wr_en;
    logic [2:0] top_idx, wr_addr, cur_idx;
    logic [7:0] wr_data, pa_level;

    ask_ramp_seq u0 (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [2:0] idx;
        logic [7:0] lev;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [2:0] m_idx;
    logic [7:0] m_tab [8];

    // Monitor: pop one prediction per falling edge and compare it
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (cur_idx !== e.idx) begin
                n_bad++;
                $display("FAIL %s cur_idx actual=%0d expected=%0d", e.tag, cur_idx, e.idx);
            end
            n_cmp++;
            if (pa_level !== e.lev) begin
                n_bad++;
                $display("FAIL %s pa_level actual=%h expected=%h", e.tag, pa_level, e.lev);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the predicted outputs
    task automatic step(input logic d, input logic tk, input logic [2:0] top,
                        input logic we, input logic [2:0] wa, input logic [7:0] wd,
                        input string tag);
        logic [2:0] tgt, nidx;
        logic [7:0] nlev;
        data_bit = d; step_tick = tk; top_idx = top;
        wr_en = we; wr_addr = wa; wr_data = wd;
        tgt  = d ? top : 3'd0;
        nidx = m_idx;
        if (tk && m_idx < tgt) nidx = m_idx + 3'd1;
        else if (tk && m_idx > tgt) nidx = m_idx - 3'd1;
        nlev = m_tab[m_idx];
        if (we) m_tab[wa] = wd;
        m_idx = nidx;
        @(posedge clk);
        exp_q.push_back('{idx: nidx, lev: nlev, tag: tag});
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; data_bit = 1'b1; step_tick = 1'b1; top_idx = 3'd7;
        wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00;
        m_idx = 3'd0;
        for (int i = 0; i < 8; i++) m_tab[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state held while rst_n low despite active inputs
        n_cmp++;
        if (cur_idx !== 3'd0 || pa_level !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset idx=%0d lev=%h expected 0/00", cur_idx, pa_level);
        end
        rst_n = 1'b1;
        // R1: first cycle after release, table still cleared
        step(1'b0, 1'b0, 3'd7, 1'b0, 3'd0, 8'h00, "R1");
        // R2: load distinct settings into every entry
        for (int i = 0; i < 8; i++)
            step(1'b0, 1'b0, 3'd7, 1'b1, 3'(i), 8'(8'h11 * i + 8'h05), "R2");
        // R7: data 1 but no tick, index holds
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd7, 1'b0, 3'd0, 8'h00, "R7");
        // R3: full ramp up with saturation at top
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R3");
        // R4: ramp down with ticks every other cycle, then saturate at 0
        for (int i = 0; i < 18; i++) step(1'b0, 1'(i % 2), 3'd7, 1'b0, 3'd0, 8'h00, "R4");
        // R5: reverse partway up
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R5");
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R5");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R5");
        // R6: reach 7, then lower top to 2
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R6");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 8'h00, "R6");
        // R8: overwrite the entry in use; new value appears one cycle later
        step(1'b1, 1'b0, 3'd2, 1'b1, 3'd2, 8'hA7, "R8");
        step(1'b1, 1'b0, 3'd2, 1'b0, 3'd0, 8'h00, "R8");
        step(1'b1, 1'b0, 3'd2, 1'b0, 3'd0, 8'h00, "R8");
        // R9: on-off keying with top 1
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 8'h00, "R9");
        for (int i = 0; i < 8; i++) step(1'(i / 2 % 2), 1'b1, 3'd1, 1'b0, 3'd0, 8'h00, "R9");
        // R10: top 0, data toggles, index stays 0
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 8'h00, "R10");
        for (int i = 0; i < 6; i++) step(1'(i % 2 == 0), 1'b1, 3'd0, 1'b0, 3'd0, 8'h00, "R10");
        // R5: reverse from the top on the way down
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R5");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R5");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, "R5");
        step(1'b0, 1'b0, 3'd7, 1'b0, 3'd0, 8'h00, "R7");
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule